// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block decides when the CPU clock of a small microcontroller core may run, and when the oscillator and peripheral clocks are switched off. The core asks for a low-power state with a one-cycle request strobe and a level that picks the state. The request stays pending until the core reports that its instruction pipeline is empty, so that no instruction is frozen half-way. Only then is the CPU clock enable dropped, and always from a register at a clock edge.

Two levels are offered. In light sleep the CPU clock is off, but the oscillator and the peripheral clock (counter/timers and the interrupt inputs) keep running. The block wakes when an interrupt is pending on a source whose enable bit is set, and it marks the wake with a one-cycle pulse. The core then resumes after the sleep instruction once the interrupt has been serviced. In deep sleep the oscillator and the peripheral clock are also switched off, and only reset ends the state.

Every reset, whether at power-up or to leave deep sleep, starts with the oscillator enabled and the CPU clock held off for a fixed stabilization count. At the end of that count the CPU clock is released, and a restart-address load carrying 000Ch is issued in the same cycle.

States: WARMUP (oscillator settling after reset), RUN (CPU clocked), DRAIN (sleep request pending, waiting for the empty pipeline), LIGHT (light sleep), DEEP (deep sleep). Transitions: WARMUP→RUN when the stabilization count completes; RUN→LIGHT or RUN→DEEP on a request while the pipeline is empty; RUN→DRAIN on a request while the pipeline is busy; DRAIN→LIGHT or DRAIN→DEEP when the pipeline becomes empty; LIGHT→RUN on an enabled pending interrupt; any state→WARMUP on reset.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted, and for STAB_CYCLES (default 1024) rising edges after it is released, osc_en is 1 and cpu_clk_en, periph_clk_en, wake_pulse and restart_load are 0.
- R2: On the STAB_CYCLES-th rising edge after reset is released, cpu_clk_en and periph_clk_en go to 1. For that one cycle only, restart_load is 1 and restart_addr is 16'h000C.
- R3: A sleep_req sampled at an edge while in RUN with pipe_empty 1 clears cpu_clk_en from that edge on. cpu_clk_en never falls unless pipe_empty was 1 at that edge.
- R4: A sleep_req sampled while pipe_empty is 0 leaves cpu_clk_en at 1. The block enters the mode that sleep_deep selected at the request (0 light, 1 deep) at the first later edge where pipe_empty is 1.
- R5: In light sleep, cpu_clk_en is 0 and osc_en and periph_clk_en are 1.
- R6: In light sleep, an edge that sees any source pending with its enable bit set returns the block to RUN: cpu_clk_en is 1 and wake_pulse is 1 after that edge. Source bit i of irq_enable enables ext_irq[i] for i from 0 to 3; bit 4 enables timer_irq.
- R7: In light sleep, pending sources whose enable bits are 0 leave the block asleep, with the outputs unchanged.
- R8: In deep sleep, cpu_clk_en, periph_clk_en and osc_en are 0. No interrupt or request changes them; only reset does.
- R9: A sleep_req sampled while in DRAIN, LIGHT, DEEP or WARMUP has no effect on the outputs or on the mode that was selected.
- R10: wake_pulse is high for exactly one cycle per exit from light sleep and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter a low-power state |
| sleep_deep | input | 1 | Mode select at the request: 0 light, 1 deep |
| pipe_empty | input | 1 | Core instruction pipeline is empty |
| ext_irq | input | N_EXT_IRQ | Pending flags of the external interrupt inputs |
| timer_irq | input | 1 | Pending flag of the timer interrupt |
| irq_enable | input | N_EXT_IRQ+1 | Enable mask: [3:0] external, [4] timer |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Timer and interrupt-logic clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle marker of a light-sleep exit |
| restart_load | output | 1 | One-cycle load of the restart fetch address |
| restart_addr | output | ADDR_W | Restart fetch address, 000Ch |

## Verification
Every output comes from a register, so each result is due one rising edge after the inputs that cause it are sampled. The only exception is reset, which acts at once. The bench changes its inputs on the falling edge, advances a cycle-level model of the requirements at the rising edge, and compares all outputs at the next falling edge. A sleep entry, a wake pulse and a drained request are therefore each checked exactly one cycle after their cause. The release after reset is checked at the 1024th edge after reset is removed, and the edge before it is checked as well. Because the model carries the DRAIN wait across as many cycles as pipe_empty stays low, random pipe_empty patterns check the delayed entry at the cycle where it is due.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        LP_WARMUP = 3'd0,
        LP_RUN    = 3'd1,
        LP_DRAIN  = 3'd2,
        LP_LIGHT  = 3'd3,
        LP_DEEP   = 3'd4
    } lp_state_t;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
    } lp_gate_t;

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
    parameter int N_SRC = 5
) (
    input  logic [N_SRC-1:0] pending,
    input  logic [N_SRC-1:0] enable,
    output logic             any_hit
);
    logic [N_SRC-1:0] hit;

    // one gate per interrupt source
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = pending[i] & enable[i];
    end

    assign any_hit = |hit;
endmodule

// File: rtl/lpm_stab_counter.sv
module lpm_stab_counter #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sleep_deep,
    input  logic pipe_empty,
    input  logic wake_hit,
    input  logic stab_done,
    output logic in_warmup,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_en,
    output logic wake_pulse,
    output logic restart_load
);
    lp_state_t state, state_nxt;
    logic      deep_sel;
    lp_gate_t  gate_nxt;

    assign in_warmup = (state == LP_WARMUP);

    // state register and captured mode select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= LP_WARMUP;
            deep_sel <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == LP_RUN && sleep_req) begin
                deep_sel <= sleep_deep;
            end
        end
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            LP_WARMUP: begin
                if (stab_done) state_nxt = LP_RUN;
            end
            LP_RUN: begin
                if (sleep_req) begin
                    if (!pipe_empty)     state_nxt = LP_DRAIN;
                    else if (sleep_deep) state_nxt = LP_DEEP;
                    else                 state_nxt = LP_LIGHT;
                end
            end
            LP_DRAIN: begin
                if (pipe_empty) state_nxt = deep_sel ? LP_DEEP : LP_LIGHT;
            end
            LP_LIGHT: begin
                if (wake_hit) state_nxt = LP_RUN;
            end
            LP_DEEP: begin
                state_nxt = LP_DEEP;
            end
            default: state_nxt = LP_WARMUP;
        endcase
    end

    // gate values belonging to the state being entered
    always_comb begin
        gate_nxt.cpu    = (state_nxt == LP_RUN) || (state_nxt == LP_DRAIN);
        gate_nxt.periph = gate_nxt.cpu || (state_nxt == LP_LIGHT);
        gate_nxt.osc    = (state_nxt != LP_DEEP);
    end

    // registered outputs, so every gate changes on an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_en    <= 1'b0;
            periph_clk_en <= 1'b0;
            osc_en        <= 1'b1;
            wake_pulse    <= 1'b0;
            restart_load  <= 1'b0;
        end else begin
            cpu_clk_en    <= gate_nxt.cpu;
            periph_clk_en <= gate_nxt.periph;
            osc_en        <= gate_nxt.osc;
            wake_pulse    <= (state == LP_LIGHT)  && (state_nxt == LP_RUN);
            restart_load  <= (state == LP_WARMUP) && (state_nxt == LP_RUN);
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
    parameter int              N_EXT_IRQ    = 4,
    parameter int              STAB_CYCLES  = 1024,
    parameter int              ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 16'h000C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 sleep_deep,
    input  logic                 pipe_empty,
    input  logic [N_EXT_IRQ-1:0] ext_irq,
    input  logic                 timer_irq,
    input  logic [N_EXT_IRQ:0]   irq_enable,
    output logic                 cpu_clk_en,
    output logic                 periph_clk_en,
    output logic                 osc_en,
    output logic                 wake_pulse,
    output logic                 restart_load,
    output logic [ADDR_W-1:0]    restart_addr
);
    localparam int N_SRC = N_EXT_IRQ + 1;

    logic wake_hit;
    logic stab_done;
    logic in_warmup;

    lpm_wake_detect #(.N_SRC(N_SRC)) u_wake (
        .pending (({timer_irq, ext_irq})),
        .enable  (irq_enable),
        .any_hit (wake_hit)
    );

    lpm_stab_counter #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_warmup),
        .done  (stab_done)
    );

    lpm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .sleep_deep    (sleep_deep),
        .pipe_empty    (pipe_empty),
        .wake_hit      (wake_hit),
        .stab_done     (stab_done),
        .in_warmup     (in_warmup),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .wake_pulse    (wake_pulse),
        .restart_load  (restart_load)
    );

    assign restart_addr = RESTART_ADDR;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int N_EXT_IRQ = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pipe_empty,
    input logic [N_EXT_IRQ-1:0] ext_irq,
    input logic                 timer_irq,
    input logic [N_EXT_IRQ:0]   irq_enable,
    input logic                 cpu_clk_en,
    input logic                 osc_en,
    input logic                 wake_pulse,
    input logic                 restart_load
);
    AST_CLK_DROP_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_en) |-> $past(pipe_empty)); // R3

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R10

    AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(|({timer_irq, ext_irq} & irq_enable))); // R6

    AST_OSC_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !osc_en); // R8

    AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> osc_en); // R8

    AST_LOAD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_load |-> $rose(cpu_clk_en)); // R2
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_EXT_IRQ(N_EXT_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pipe_empty   (pipe_empty),
    .ext_irq      (ext_irq),
    .timer_irq    (timer_irq),
    .irq_enable   (irq_enable),
    .cpu_clk_en   (cpu_clk_en),
    .osc_en       (osc_en),
    .wake_pulse   (wake_pulse),
    .restart_load (restart_load)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
    localparam int STAB = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        sleep_deep = 1'b0;
    logic        pipe_empty = 1'b1;
    logic [3:0]  ext_irq = '0;
    logic        timer_irq = 1'b0;
    logic [4:0]  irq_enable = '0;
    logic        cpu_clk_en, periph_clk_en, osc_en, wake_pulse, restart_load;
    logic [15:0] restart_addr;

    int checks = 0;
    int errors = 0;

    // model of the requirements: 0 warmup, 1 run, 2 drain, 3 light, 4 deep
    int   m_st = 0;
    int   m_cnt = 0;
    logic m_deep = 1'b0;
    logic e_cpu = 0, e_per = 0, e_osc = 1, e_wake = 0, e_load = 0;

    always #4 clk = ~clk;

    lpm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .pipe_empty(pipe_empty), .ext_irq(ext_irq), .timer_irq(timer_irq),
        .irq_enable(irq_enable), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .wake_pulse(wake_pulse), .restart_load(restart_load),
        .restart_addr(restart_addr)
    );

    function automatic logic enabled_pending(logic [3:0] e, logic t, logic [4:0] m);
        return |({t, e} & m);
    endfunction

    task automatic check(string tag);
        logic [4:0] act, exp;
        act = {cpu_clk_en, periph_clk_en, osc_en, wake_pulse, restart_load};
        exp = {e_cpu, e_per, e_osc, e_wake, e_load};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {cpu,per,osc,wake,load} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
        if (e_load) begin
            checks++;
            if (restart_addr !== 16'h000C) begin
                errors++;
                $display("FAIL R2: restart_addr actual=%h expected=000c", restart_addr);
            end
        end
    endtask

    // advance model over one rising edge, then compare at the falling edge
    task automatic step(string tag);
        @(posedge clk);
        e_wake = 0;
        e_load = 0;
        case (m_st)
            0: if (m_cnt == STAB - 1) begin m_st = 1; e_load = 1; end else m_cnt++;
            1: if (sleep_req) begin
                   m_deep = sleep_deep;
                   m_st = !pipe_empty ? 2 : (sleep_deep ? 4 : 3);
               end
            2: if (pipe_empty) m_st = m_deep ? 4 : 3;
            3: if (enabled_pending(ext_irq, timer_irq, irq_enable)) begin m_st = 1; e_wake = 1; end
            default: ;
        endcase
        e_cpu = (m_st == 1) || (m_st == 2);
        e_per = e_cpu || (m_st == 3);
        e_osc = (m_st != 4);
        @(negedge clk);
        sleep_req = 1'b0;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sleep_req = 1'b0;
        m_st = 0; m_cnt = 0; m_deep = 0;
        e_cpu = 0; e_per = 0; e_osc = 1; e_wake = 0; e_load = 0;
        #1;
        check("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < STAB - 1; i++) step("R1 warmup");
        step("R2 release");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));

        do_reset();
        step("R2 load gone");

        // light sleep with empty pipeline
        sleep_req = 1; sleep_deep = 0; pipe_empty = 1;
        step("R3 R5 enter light");
        ext_irq = 4'b0101; irq_enable = 5'b00010;
        step("R7 masked stays asleep");
        sleep_req = 1; sleep_deep = 1;
        step("R9 request in light ignored");
        step("R7 still asleep");
        irq_enable = 5'b00001;
        step("R6 wake");
        step("R10 pulse ends");
        ext_irq = 0;

        // delayed entry to deep sleep
        pipe_empty = 0; sleep_req = 1; sleep_deep = 1;
        step("R4 draining");
        step("R4 still draining");
        sleep_req = 1; sleep_deep = 0;
        step("R9 request in drain ignored");
        pipe_empty = 1;
        step("R4 R8 enter deep");
        ext_irq = 4'hF; timer_irq = 1; irq_enable = 5'h1F; sleep_req = 1;
        step("R8 deep ignores irq");
        step("R8 deep holds");
        ext_irq = 0; timer_irq = 0;
        do_reset();

        // timer wake
        sleep_req = 1; sleep_deep = 0; irq_enable = 5'b10000;
        step("R5 light");
        timer_irq = 1;
        step("R6 timer wake");
        timer_irq = 0;
        step("R10 pulse ends");

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            sleep_req  = ($urandom % 6) == 0;
            sleep_deep = ($urandom % 5) == 0;
            pipe_empty = ($urandom % 3) != 0;
            ext_irq    = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            timer_irq  = ($urandom % 10) == 0;
            irq_enable = 5'($urandom);
            if (m_st == 4 && ($urandom % 16) == 0) begin
                do_reset();
            end else begin
                step("R3 R4 R6 R7 R10 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule